// File: doc/BRIEF.md
# Flash Block-Write Buffer Controller

This controller lets software update a word-organised program memory, which is modelled here as a register array. Software uses a byte-wide register bus. Through it, software loads a target word address and a data word, writes a two-byte unlock key, and then sets a write-request bit in a control register. The data word is parked in one of four staging slots. The two low address bits choose the slot.

While the word goes to slots 0, 1 or 2, nothing reaches the array, and the operation ends after its setup cycles. A word sent to slot 3 starts a commit. The commit blanks every word of the aligned 16-word row that holds the address, setting each to all ones. It then copies the four staged words into the aligned four-word group. A read request copies the addressed array word into the data register, where software can see it.

The sequencer has five named states.

- IDLE moves to SETUP1 on an accepted write request.
- SETUP1 always moves to SETUP2.
- SETUP2 moves to ERASE when the slot is 3, and otherwise back to IDLE after it loads the slot.
- ERASE spends one cycle per row word, then moves to PROG.
- PROG spends one cycle per group word, then returns to IDLE.

The unlock tracker has three named states.

- K_IDLE moves to K_HALF when 55h is written to the key register.
- K_HALF moves to K_ARMED when the next bus write is AAh to the key register. Any other bus write returns it to K_IDLE.
- K_ARMED returns to K_IDLE on any bus write. If that write is a control write with the write bit set, it starts an operation.

Top module: `flashbuf_ctrl`

## Requirements
- R1: A write request (control bit 1) is accepted only when the two bus writes just before it were key 55h and then key AAh. A control write with bit 1 set that does not follow this is ignored: busy stays 0.
- R2: During the key sequence, any bus write other than the expected next one returns the unlock tracker to its start. A fresh 55h, AAh pair is then needed.
- R3: An accepted write whose address low bits are 00, 01 or 10 only stores the data word in that slot. Program memory is unchanged.
- R4: An accepted write whose address low bits are 11 sets all 16 words of the aligned row (address bits above bit 3 equal) to all ones. Row words outside the four-word group read all ones afterwards.
- R5: After the row erase, the four staged words are written to the group addresses with low bits 00, 01, 10 and 11, in slot order. Any slot not written since the last commit keeps its previous content, which is all ones after reset.
- R6: Every accepted write spends two setup cycles before any buffer or memory update. Busy therefore stays high for 2 cycles for slots 0 to 2, and for 22 cycles (2 + 16 + 4) for slot 3.
- R7: A control write with bit 0 set, and no accepted write in the same cycle, loads the array word at the address register into the data register. The data register changes only on such a read or on a bus write to a data byte.
- R8: Busy falls by itself when the operation ends. While busy is high, all bus writes are ignored.
- R9: Memory updates never leave the aligned row (erase) or the aligned group (program) of the latched address, and the latched address is held for the whole operation.
- R10: After reset, busy is 0, data_q is 0, the address register is 0, and every memory word and staging slot is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_sel | input | 3 | Register select: 0 address low, 1 address high, 2 data low, 3 data high, 4 key, 5 control (bit 0 read, bit 1 write) |
| bus_wdata | input | 8 | Register write byte |
| data_q | output | DATA_W | Data register contents (last read word or user-written word) |
| busy | output | 1 | High while a write operation is in progress |

## Verification
The assertions check every cycle that:

- the unlock tracker reaches K_ARMED only straight after an AAh key write, and drops back on a mismatch;
- SETUP1 is always followed by SETUP2;
- the erase hands over to programming at the row end;
- the address and data registers and the latched address hold still while busy;
- the data register moves only on a read or a data-byte write.

Only the bench scenarios can show the stored contents: that erased row words read all ones, that staged words land at the right group addresses, that partial groups leave memory untouched, and that broken key sequences leave the array unchanged.

// File: rtl/flashbuf_pkg.sv
package flashbuf_pkg;
    typedef enum logic [1:0] {K_IDLE, K_HALF, K_ARMED} key_state_t;
    typedef enum logic [2:0] {S_IDLE, S_SETUP1, S_SETUP2, S_ERASE, S_PROG} seq_state_t;

    localparam logic [2:0] SEL_ADDR_LO = 3'd0;
    localparam logic [2:0] SEL_ADDR_HI = 3'd1;
    localparam logic [2:0] SEL_DATA_LO = 3'd2;
    localparam logic [2:0] SEL_DATA_HI = 3'd3;
    localparam logic [2:0] SEL_KEY     = 3'd4;
    localparam logic [2:0] SEL_CTRL    = 3'd5;

    localparam logic [7:0] KEY_FIRST  = 8'h55;
    localparam logic [7:0] KEY_SECOND = 8'hAA;

    localparam int CTRL_RD_BIT = 0;
    localparam int CTRL_WR_BIT = 1;
endpackage

// File: rtl/flashbuf_unlock.sv
module flashbuf_unlock
    import flashbuf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_ok,
    input  logic [2:0] sel,
    input  logic [7:0] wdata,
    output logic       start
);
    key_state_t state, state_nx;
    logic key_wr;

    assign key_wr = bus_ok && (sel == SEL_KEY);

    always_ff @(posedge clk) begin
        if (!rst_n) state <= K_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        if (bus_ok) begin
            unique case (state)
                K_IDLE:  if (key_wr && wdata == KEY_FIRST) state_nx = K_HALF;
                K_HALF:  state_nx = (key_wr && wdata == KEY_SECOND) ? K_ARMED : K_IDLE;
                K_ARMED: state_nx = K_IDLE;
                default: state_nx = K_IDLE;
            endcase
        end
    end

    always_comb begin
        start = bus_ok && (state == K_ARMED) && (sel == SEL_CTRL) && wdata[CTRL_WR_BIT];
    end

    // R1: armed only right after the second key byte
    assert_armed_after_key_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == K_ARMED) |-> $past(bus_ok && sel == SEL_KEY && wdata == KEY_SECOND));

    // R2: a wrong write in the half state drops the sequence
    assert_mismatch_reset_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ok && state == K_HALF && !(sel == SEL_KEY && wdata == KEY_SECOND)) |=> (state == K_IDLE));
endmodule

// File: rtl/flashbuf_seq.sv
module flashbuf_seq
    import flashbuf_pkg::*;
#(
    parameter int ROW_WORDS = 16,
    parameter int BLK_WORDS = 4,
    localparam int CNT_W = $clog2(ROW_WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             last_slot,
    output logic             busy,
    output logic             buf_load,
    output logic             erase_we,
    output logic             prog_we,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] ROW_LAST = CNT_W'(ROW_WORDS - 1);
    localparam logic [CNT_W-1:0] BLK_LAST = CNT_W'(BLK_WORDS - 1);

    seq_state_t state, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            if (state != state_nx)                          cnt <= '0;
            else if (state == S_ERASE || state == S_PROG)   cnt <= cnt + 1'b1;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:   if (start) state_nx = S_SETUP1;
            S_SETUP1: state_nx = S_SETUP2;
            S_SETUP2: state_nx = last_slot ? S_ERASE : S_IDLE;
            S_ERASE:  if (cnt == ROW_LAST) state_nx = S_PROG;
            S_PROG:   if (cnt == BLK_LAST) state_nx = S_IDLE;
            default:  state_nx = S_IDLE;
        endcase
    end

    always_comb begin
        busy     = (state != S_IDLE);
        buf_load = (state == S_SETUP2);
        erase_we = (state == S_ERASE);
        prog_we  = (state == S_PROG);
    end

    // R6: two setup cycles always precede any update
    assert_setup_pair_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_SETUP1) |=> (state == S_SETUP2));

    // R4: the full row is erased before programming starts
    assert_erase_to_prog_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_ERASE && cnt == ROW_LAST) |=> (state == S_PROG && cnt == '0));

    // R5: programming stays within the group length
    assert_prog_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        prog_we |-> (cnt <= BLK_LAST));

    // R8: busy falls after programming the last word
    assert_auto_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_we && cnt == BLK_LAST) |=> !busy);
endmodule

// File: rtl/flashbuf_mem.sv
module flashbuf_mem #(
    parameter int ADDR_W = 9,
    parameter int DATA_W = 14,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= '1;
        end else if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/flashbuf_ctrl.sv
module flashbuf_ctrl
    import flashbuf_pkg::*;
#(
    parameter int ADDR_W    = 9,
    parameter int DATA_W    = 14,
    parameter int ROW_WORDS = 16,
    parameter int BLK_WORDS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [2:0]        bus_sel,
    input  logic [7:0]        bus_wdata,
    output logic [DATA_W-1:0] data_q,
    output logic              busy
);
    localparam int ROW_SH = $clog2(ROW_WORDS);
    localparam int BLK_SH = $clog2(BLK_WORDS);
    localparam int AHI_W  = ADDR_W - 8;
    localparam int DHI_W  = DATA_W - 8;

    logic [ADDR_W-1:0] addr_reg, op_addr, mem_waddr;
    logic [DATA_W-1:0] data_reg, op_data, mem_wdata, mem_rdata;
    logic [DATA_W-1:0] stage [BLK_WORDS];
    logic [ROW_SH-1:0] cnt;
    logic bus_ok, start, buf_load, erase_we, prog_we, last_slot, rd_fire, data_wr;

    assign bus_ok    = bus_we && !busy;
    assign rd_fire   = bus_ok && (bus_sel == SEL_CTRL) && bus_wdata[CTRL_RD_BIT] && !start;
    assign data_wr   = bus_ok && (bus_sel == SEL_DATA_LO || bus_sel == SEL_DATA_HI);
    assign last_slot = &op_addr[BLK_SH-1:0];

    flashbuf_unlock u_unlock (
        .clk(clk), .rst_n(rst_n), .bus_ok(bus_ok),
        .sel(bus_sel), .wdata(bus_wdata), .start(start)
    );

    flashbuf_seq #(.ROW_WORDS(ROW_WORDS), .BLK_WORDS(BLK_WORDS)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .last_slot(last_slot),
        .busy(busy), .buf_load(buf_load), .erase_we(erase_we),
        .prog_we(prog_we), .cnt(cnt)
    );

    always_comb begin
        if (erase_we) begin
            mem_waddr = {op_addr[ADDR_W-1:ROW_SH], cnt};
            mem_wdata = '1;
        end else begin
            mem_waddr = {op_addr[ADDR_W-1:BLK_SH], cnt[BLK_SH-1:0]};
            mem_wdata = stage[cnt[BLK_SH-1:0]];
        end
    end

    flashbuf_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
        .clk(clk), .rst_n(rst_n), .we(erase_we || prog_we),
        .waddr(mem_waddr), .wdata(mem_wdata),
        .raddr(addr_reg), .rdata(mem_rdata)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_reg <= '0;
            data_reg <= '0;
            op_addr  <= '0;
            op_data  <= '0;
        end else begin
            if (bus_ok && bus_sel == SEL_ADDR_LO) addr_reg[7:0]        <= bus_wdata;
            if (bus_ok && bus_sel == SEL_ADDR_HI) addr_reg[ADDR_W-1:8] <= bus_wdata[AHI_W-1:0];
            if (bus_ok && bus_sel == SEL_DATA_LO) data_reg[7:0]        <= bus_wdata;
            if (bus_ok && bus_sel == SEL_DATA_HI) data_reg[DATA_W-1:8] <= bus_wdata[DHI_W-1:0];
            if (rd_fire) data_reg <= mem_rdata;
            if (start) begin
                op_addr <= addr_reg;
                op_data <= data_reg;
            end
        end
    end

    generate
        for (genvar s = 0; s < BLK_WORDS; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (!rst_n)                                         stage[s] <= '1;
                else if (buf_load && op_addr[BLK_SH-1:0] == BLK_SH'(s)) stage[s] <= op_data;
            end
        end
    endgenerate

    assign data_q = data_reg;

    // R8: bus writes while busy leave the registers alone
    assert_ignore_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(addr_reg) && $stable(data_reg)));

    // R9: the latched operation address holds during the operation
    assert_op_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !buf_load && !(prog_we && cnt == ROW_SH'(BLK_WORDS - 1))) |=> $stable(op_addr));

    // R7: data register moves only on a read or a data-byte write
    assert_data_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(data_reg) |-> $past(rd_fire || data_wr));

    // R1: an operation starts only from idle
    assert_start_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);
endmodule

// File: tb/tb_flashbuf_ctrl.sv
module tb_flashbuf_ctrl;
    localparam int AW = 9;
    localparam int DW = 14;
    localparam int DEPTH = 1 << AW;
    localparam logic [DW-1:0] ONES = '1;

    logic clk = 0, rst_n = 0, bus_we = 0;
    logic [2:0] bus_sel = 0;
    logic [7:0] bus_wdata = 0;
    logic [DW-1:0] data_q;
    logic busy;

    int tests = 0, fails = 0;
    bit done = 0;
    logic [DW-1:0] ref_mem [DEPTH];
    logic [DW-1:0] ref_stage [4];

    flashbuf_ctrl dut (.clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_sel(bus_sel),
                       .bus_wdata(bus_wdata), .data_q(data_q), .busy(busy));

    always #10 clk = ~clk;

    function automatic int exp_busy(input int addr);
        return ((addr & 3) == 3) ? 22 : 2;
    endfunction

    function automatic int row_base(input int addr);
        return addr & ~15;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bw(input logic [2:0] s, input logic [7:0] d);
        @(negedge clk);
        bus_we = 1; bus_sel = s; bus_wdata = d;
        @(negedge clk);
        bus_we = 0;
    endtask

    task automatic busy_len(output int n);
        n = 0;
        while (busy && n < 100) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic set_addr_data(input int addr, input logic [DW-1:0] d);
        bw(0, addr[7:0]); bw(1, 8'(addr >> 8));
        bw(2, d[7:0]);    bw(3, 8'(d >> 8));
    endtask

    task automatic model_write(input int addr, input logic [DW-1:0] d);
        ref_stage[addr & 3] = d;
        if ((addr & 3) == 3) begin
            for (int i = 0; i < 16; i++) ref_mem[row_base(addr) + i] = ONES;
            for (int i = 0; i < 4; i++) ref_mem[(addr & ~3) + i] = ref_stage[i];
        end
    endtask

    task automatic do_write(input int addr, input logic [DW-1:0] d, input string req);
        int n;
        set_addr_data(addr, d);
        bw(4, 8'h55); bw(4, 8'hAA); bw(5, 8'h02);
        busy_len(n);
        chk(n == exp_busy(addr), req, n, exp_busy(addr));
        model_write(addr, d);
    endtask

    task automatic do_read(input int addr, input string req);
        bw(0, addr[7:0]); bw(1, 8'(addr >> 8)); bw(5, 8'h01);
        chk(data_q == ref_mem[addr], req, int'(data_q), int'(ref_mem[addr]));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int n, a;
        logic [DW-1:0] d, held;
        void'($urandom(32'd20240611));
        for (int i = 0; i < DEPTH; i++) ref_mem[i] = ONES;
        for (int i = 0; i < 4; i++) ref_stage[i] = ONES;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R10 reset state
        chk(busy == 0, "R10 busy", busy, 0);
        chk(data_q == 0, "R10 data_q", int'(data_q), 0);
        bw(5, 8'h01);
        chk(data_q == ONES, "R10 mem ones", int'(data_q), int'(ONES));

        // R1 write without unlock is ignored
        set_addr_data(12'h023, 14'h1234);
        bw(5, 8'h02); busy_len(n);
        chk(n == 0, "R1 no key", n, 0);
        do_read(12'h023, "R1 mem unchanged");

        // R2 broken sequences
        set_addr_data(12'h043, 14'h0abc);
        bw(4, 8'h55); bw(4, 8'h55); bw(4, 8'hAA); bw(5, 8'h02); busy_len(n);
        chk(n == 0, "R2 double 55", n, 0);
        bw(4, 8'h55); bw(0, 8'h43); bw(4, 8'hAA); bw(5, 8'h02); busy_len(n);
        chk(n == 0, "R2 write between keys", n, 0);
        bw(4, 8'h55); bw(4, 8'hAA); bw(2, 8'hbc); bw(5, 8'h02); busy_len(n);
        chk(n == 0, "R1 write after key", n, 0);
        do_read(12'h043, "R2 mem unchanged");
        // R2 fresh pair works after failure
        do_write(12'h040, 14'h0111, "R2 recovery accepted");

        // R3 partial group leaves memory untouched
        do_write(12'h041, 14'h0222, "R6 slot1 busy");
        do_write(12'h042, 14'h0333, "R6 slot2 busy");
        for (int i = 0; i < 4; i++) do_read(12'h040 + i, "R3 partial no effect");

        // R4 R5 commit group
        do_write(12'h043, 14'h0444, "R6 slot3 busy");
        for (int i = 0; i < 16; i++) do_read(12'h040 + i, "R4 R5 row after commit");

        // R5 R4: lone slot3 re-uses staged words, erases rest of row
        do_write(12'h04d, 14'h2aaa, "R6 slot1 other group");
        do_write(12'h04f, 14'h3555, "R6 lone slot3");
        for (int i = 0; i < 16; i++) do_read(12'h040 + i, "R4 R5 second commit");

        // R7 hold and user write
        do_read(12'h04c, "R7 read");
        held = data_q;
        bw(0, 8'h00); bw(1, 8'h00);
        repeat (5) @(negedge clk);
        chk(data_q == held, "R7 hold", int'(data_q), int'(held));
        bw(2, 8'h5a);
        chk(data_q[7:0] == 8'h5a, "R7 user write", int'(data_q[7:0]), 8'h5a);

        // R8 writes during busy ignored
        set_addr_data(12'h080, 14'h0777);
        bw(4, 8'h55); bw(4, 8'hAA); bw(5, 8'h02);
        bw(0, 8'h99);
        busy_len(n);
        model_write(12'h080, 14'h0777);
        bw(5, 8'h01);
        chk(data_q == ref_mem[12'h080], "R8 addr ignored while busy", int'(data_q), int'(ref_mem[12'h080]));
        chk(busy == 0, "R8 busy cleared", busy, 0);

        // random blocks, R9 neighbours untouched
        for (int it = 0; it < 30; it++) begin
            a = $urandom_range(0, DEPTH / 4 - 1) * 4;
            for (int s = 0; s < 4; s++) begin
                d = DW'($urandom);
                do_write(a + s, d, "R6 random busy");
            end
            for (int i = 0; i < 16; i++) do_read(row_base(a) + i, "R4 R5 random row");
            if (row_base(a) >= 16) do_read(row_base(a) - 1, "R9 lower neighbour");
            if (row_base(a) + 16 < DEPTH) do_read(row_base(a) + 16, "R9 upper neighbour");
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule